// File: doc/BRIEF.md
# Word-Addressed Instruction Fetch Unit

This block holds the program counter of a 32-bit processor whose instructions are all four bytes wide, and it chooses the next fetch address on every cycle. Because every fetch address is word aligned, only the upper thirty bits of the counter are stored. The two byte-select bits are tied to zero on the way out. Increments and branch offsets are therefore added in word units, with no shift.

The surrounding core supplies the current instruction word and two select lines. The first, a branch-taken flag, comes from a comparison made elsewhere. The second, a jump select, comes from the decoder. The block offers three successors:
- a plain step to the next word;
- a relative branch, using the signed 16-bit offset in the instruction;
- an absolute jump, using the 26-bit target field and keeping the top bits of the stepped address.

The branch offset is first gated by the branch decision and then sent through a single adder, so only one adder and one multiplexer follow that late-arriving decision. The counter updates on the falling clock edge.

Top module: `word_fetch_unit`

## Requirements
- R1: Bits 1..0 of `fetch_addr` and of `seq_addr` are always zero.
- R2: `seq_addr` always equals `fetch_addr + 4`, modulo 2^32.
- R3: With `jump_sel` low and `br_taken` low, the next `fetch_addr` is the current one plus 4, and the instruction word has no effect.
- R4: With `br_taken` high and `jump_sel` low, the next `fetch_addr` is the current one plus 4 plus four times the sign-extended value of `instr[15:0]`.
- R5: With `jump_sel` high, the next `fetch_addr` is formed from three parts, from most to least significant: bits 31..28 of `seq_addr`, then `instr[25:0]`, then two zero bits.
- R6: When `jump_sel` and `br_taken` are both high, the jump result of R5 is taken and the branch offset is ignored.
- R7: When `rst` is high at a falling clock edge, `fetch_addr` becomes zero at that edge.
- R8: `fetch_addr` changes only on the falling clock edge and holds its value across the rising edge.
- R9: Branch arithmetic wraps modulo 2^32 in bytes, with no overflow indication. For example, a branch from address 0 with offset -2 yields 0xFFFFFFFC, and the step that follows yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on its falling edge |
| rst | input | 1 | Synchronous reset, active high; loads a zero counter |
| instr | input | 32 | Current instruction word; supplies the offset in bits 15..0 and the target in bits 25..0 |
| br_taken | input | 1 | Branch condition from the outside comparison |
| jump_sel | input | 1 | Selects the absolute jump successor; takes priority over `br_taken` |
| fetch_addr | output | 32 | Byte address presented to instruction memory |
| seq_addr | output | 32 | Byte address of the next sequential instruction |

## Verification
Each input set is driven just after a rising edge. Its result is due at the following falling edge, one register stage later, and `seq_addr` follows in the same instant through combinational logic. The monitor therefore compares both outputs one nanosecond after each falling edge, against the expected item that the driver queued for that edge. It then looks again one nanosecond after the next rising edge to confirm that nothing moved there. Directed steps cover reset, the 28-bit boundary that a jump keeps, negative offsets that wrap, and jump-over-branch priority, followed by a stretch of random instructions.

// File: rtl/word_fetch_unit.sv
module word_fetch_unit #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 16,
  parameter int TGT_W   = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               br_taken,
  input  logic               jump_sel,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  seq_addr
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int KEEP_W = WORD_W - TGT_W;

  logic [WORD_W-1:0] pc_w, pc_inc, br_off, pc_step, pc_nxt;
  logic              armed;

  assign pc_inc  = pc_w + WORD_W'(1);
  // offset gated by the late decision, then one adder with a +1 folded in
  assign br_off  = br_taken ? {{(WORD_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]} : '0;
  assign pc_step = pc_w + br_off + WORD_W'(1);
  assign pc_nxt  = jump_sel ? {pc_inc[WORD_W-1 -: KEEP_W], instr[TGT_W-1:0]} : pc_step;

  always_ff @(negedge clk) begin
    if (rst) begin
      pc_w  <= '0;
      armed <= 1'b0;
    end else begin
      pc_w  <= pc_nxt;
      armed <= 1'b1;
    end
  end

  assign fetch_addr = {pc_w, 2'b00};
  assign seq_addr   = {pc_inc, 2'b00};

  assert_seq_follows_R2: assert property (@(negedge clk) disable iff (rst)
    armed |-> seq_addr == fetch_addr + ADDR_W'(4));

  assert_plain_step_R3: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(jump_sel) && !$past(br_taken)) |->
      fetch_addr == $past(fetch_addr) + ADDR_W'(4));

  assert_branch_target_R4: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(jump_sel) && $past(br_taken)) |->
      fetch_addr == $past(fetch_addr) + ADDR_W'(4) +
        {{(ADDR_W-IMM_W-2){$past(instr[IMM_W-1])}}, $past(instr[IMM_W-1:0]), 2'b00});

  assert_jump_target_R5: assert property (@(negedge clk) disable iff (rst)
    (armed && $past(jump_sel)) |->
      fetch_addr == {$past(seq_addr[ADDR_W-1 -: KEEP_W]), $past(instr[TGT_W-1:0]), 2'b00});

  assert_jump_wins_R6: assert property (@(negedge clk) disable iff (rst)
    (armed && $past(jump_sel) && $past(br_taken)) |->
      fetch_addr[TGT_W+1:2] == $past(instr[TGT_W-1:0]));
endmodule

// File: tb/sim_word_fetch_unit.sv
module sim_word_fetch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        br_taken = 1'b0;
  logic        jump_sel = 1'b0;
  logic [31:0] fetch_addr, seq_addr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model = '0;
  logic [31:0] last_seen = '0;

  always #2 clk = ~clk;

  word_fetch_unit u0 (.clk(clk), .rst(rst), .instr(instr), .br_taken(br_taken),
                      .jump_sel(jump_sel), .fetch_addr(fetch_addr), .seq_addr(seq_addr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic b, input logic j,
                       input logic [31:0] ins, input string req);
    logic [31:0] nxt;
    @(posedge clk);
    rst = r; br_taken = b; jump_sel = j; instr = ins;
    nxt = model + 32'd4;
    if (r)      model = '0;
    else if (j) model = {nxt[31:28], ins[25:0], 2'b00};
    else if (b) model = nxt + {{14{ins[15]}}, ins[15:0], 2'b00};
    else        model = nxt;
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, fetch_addr, e);
        check("R2", seq_addr, e + 32'd4);
        check("R1", {30'd0, fetch_addr[1:0] | seq_addr[1:0]}, 32'd0);
        last_seen = fetch_addr;
        @(posedge clk); #1;
        check("R8", fetch_addr, last_seen);
      end
    end
  end

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin : driver
    drive(1, 0, 0, 32'h0, "R7");
    drive(1, 1, 1, 32'hFFFF_FFFF, "R7");
    drive(0, 0, 0, 32'hDEAD_BEEF, "R3");
    drive(0, 0, 0, 32'h0000_0000, "R3");
    drive(0, 1, 0, 32'h0000_0010, "R4");
    drive(0, 1, 0, 32'h0000_FFFF, "R4");
    drive(0, 0, 1, 32'h03FF_FFFF, "R5");
    drive(0, 0, 0, 32'h1234_5678, "R3");
    drive(0, 1, 1, 32'h0000_8000, "R6");
    drive(1, 0, 0, 32'h0, "R7");
    drive(0, 1, 0, 32'h0000_FFFE, "R9");
    drive(0, 0, 0, 32'h0, "R9");
    drive(0, 1, 0, 32'h0000_7FFF, "R4");
    drive(0, 1, 0, 32'h0000_8000, "R9");
    drive(0, 0, 1, 32'h0000_0001, "R5");
    drive(0, 1, 1, 32'h02AA_AAAA, "R6");
    for (int i = 0; i < 200; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      drive(sel == 0, sel inside {[1:3]} || sel == 8, sel inside {[4:5]} || sel == 8,
            $urandom(), sel == 8 ? "R6" : "R3");
    end
    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule